// File: doc/BRIEF.md
# Trapezoidal Energy Shaping Filter

This block shapes a stream of digitized preamplifier samples into a trapezoid. One 16-bit unsigned sample enters on every clock while the filter runs. The filter keeps two running boxcar sums of L samples each. The newer window covers the most recent L samples. The older window sits G samples further back, so the G samples between the windows are left out. The output is the newer sum minus the older sum. An ideal step therefore produces a ramp up over L samples, a plateau of height step×L, and a symmetric ramp down, spanning 2L+G samples in all.

Both running sums update on every running cycle without pause. A capture strobe copies the two raw sums into a holding register, so a downstream stage can reconstruct energy from them while filtering carries on. A later stage can also subtract a baseline taken from the same filter while no pulse is present.

The window length and gap are loaded only while the filter is idle (run input low). Going idle also clears the sample history, the sums and the fill counter. A valid flag shows when the history holds a full 2L+G samples.

Top module: `trap_filter`

## Requirements
- R1: After reset, len_o is 8, gap_o is 4, valid_o is 0, diff_o is 0, and both capture outputs are 0.
- R2: A load_i pulse at an edge where run_i is low loads the length clamped to the range 2..64 and the gap clamped to 0..32. Both values are visible on len_o and gap_o after that edge.
- R3: While run_i is high, load_i has no effect: len_o and gap_o keep their values.
- R4: An edge with run_i low clears the history, both sums and the fill count. After that edge, diff_o is 0 and valid_o is 0.
- R5: After each running edge, diff_o equals the sum of the newest L samples minus the sum of the samples aged L+G through 2L+G-1 (age 0 is the newest). Samples taken before the run started count as zero.
- R6: For a step of height H from a zero history, diff_o equals H×L on exactly G+1 consecutive samples and is nonzero on exactly 2L+G-1 samples.
- R7: valid_o rises after exactly 2L+G samples since the run started and stays high while run_i stays high.
- R8: At an edge where cap_i is high, cap_new_o and cap_old_o take the newer and older sums as they were just before that edge. At other edges they hold their values.
- R9: With L=64 and every sample at 65535, the sums do not overflow and diff_o reaches 4194240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: take one sample per clock. Low: idle and clear |
| load_i | input | 1 | Load len_i and gap_i (idle only) |
| len_i | input | 7 | Requested window length |
| gap_i | input | 6 | Requested gap length |
| sample_i | input | 16 | Unsigned ADC sample |
| cap_i | input | 1 | Capture strobe for both sums |
| len_o | output | 7 | Window length in use |
| gap_o | output | 6 | Gap length in use |
| diff_o | output | 23 | Signed newer-minus-older sum |
| valid_o | output | 1 | History holds 2L+G samples |
| cap_new_o | output | 22 | Captured newer-window sum |
| cap_old_o | output | 22 | Captured older-window sum |

## Verification
A single step from a zero history confirms the trapezoid geometry: the plateau count and the nonzero span tell a wrong gap tap apart from a wrong length tap. Random full-range samples, with random lengths and gaps (including out-of-range requests), compare every output against a direct window-sum model. This exposes tap-index errors that a step input hides. A constant full-scale input at the longest window checks sum width. Load and capture pulses are scattered through both idle and running phases, which separates honoured loads from ignored ones.

// File: rtl/trap_pkg.sv
package trap_pkg;
  function automatic int unsigned clamp_u(input int unsigned v, input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl import trap_pkg::*; #(
  parameter int L_MIN = 2,
  parameter int L_MAX = 64,
  parameter int G_MAX = 32,
  parameter int L_DEF = 8,
  parameter int G_DEF = 4,
  localparam int LW = $clog2(L_MAX + 1),
  localparam int GW = $clog2(G_MAX + 1),
  localparam int CW = $clog2(2 * L_MAX + G_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic [GW-1:0] gap_i,
  output logic [LW-1:0] len_o,
  output logic [GW-1:0] gap_o,
  output logic          valid_o
);
  logic [LW-1:0] len_q;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] cnt_q, span;

  assign span = CW'({len_q, 1'b0}) + CW'(gap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LW'(L_DEF);
      gap_q <= GW'(G_DEF);
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      if (load_i) begin
        len_q <= LW'(clamp_u(int'(len_i), L_MIN, L_MAX));
        gap_q <= GW'(clamp_u(int'(gap_i), 0, G_MAX));
      end
    end else if (cnt_q != span) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign len_o   = len_q;
  assign gap_o   = gap_q;
  assign valid_o = (cnt_q == span);
endmodule

// File: rtl/trap_delay_line.sv
module trap_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 160,
  parameter int NT    = 3,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DW-1:0]    d_i,
  input  logic [NT*IW-1:0] idx_i,
  output logic [NT*DW-1:0] tap_o
);
  logic [DW-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else if (en_i) begin
      hist_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_tap
    logic [IW-1:0] ix;
    assign ix = idx_i[t*IW +: IW];
    assign tap_o[t*DW +: DW] = (int'(ix) < DEPTH) ? hist_q[ix] : '0;
  end
endmodule

// File: rtl/trap_window_sum.sv
module trap_window_sum #(
  parameter int DW = 16,
  parameter int SW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] add_i,
  input  logic [DW-1:0] sub_i,
  output logic [SW-1:0] sum_o
);
  logic [SW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + SW'(add_i) - SW'(sub_i);
  end

  assign sum_o = acc_q;
endmodule

// File: rtl/trap_filter.sv
module trap_filter #(
  parameter int DW    = 16,
  parameter int L_MIN = 2,
  parameter int L_MAX = 64,
  parameter int G_MAX = 32,
  parameter int L_DEF = 8,
  parameter int G_DEF = 4,
  localparam int LW    = $clog2(L_MAX + 1),
  localparam int GW    = $clog2(G_MAX + 1),
  localparam int DEPTH = 2 * L_MAX + G_MAX,
  localparam int IW    = $clog2(DEPTH),
  localparam int SW    = DW + $clog2(L_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic [GW-1:0] gap_i,
  input  logic [DW-1:0] sample_i,
  input  logic          cap_i,
  output logic [LW-1:0] len_o,
  output logic [GW-1:0] gap_o,
  output logic [SW:0]   diff_o,
  output logic          valid_o,
  output logic [SW-1:0] cap_new_o,
  output logic [SW-1:0] cap_old_o
);
  logic [LW-1:0]   len_w;
  logic [GW-1:0]   gap_w;
  logic [3*IW-1:0] idx;
  logic [3*DW-1:0] taps;
  logic [SW-1:0]   sum_new, sum_old;
  logic [SW-1:0]   cap_new_q, cap_old_q;

  trap_ctrl #(.L_MIN(L_MIN), .L_MAX(L_MAX), .G_MAX(G_MAX), .L_DEF(L_DEF), .G_DEF(G_DEF)) u_ctrl (
    .clk_i, .rst_ni, .run_i, .load_i, .len_i, .gap_i,
    .len_o(len_w), .gap_o(gap_w), .valid_o
  );

  // taps: age L-1 leaves newer window, ages L+G-1 / 2L+G-1 enter/leave older
  assign idx[0*IW +: IW] = IW'(len_w) - 1'b1;
  assign idx[1*IW +: IW] = IW'(len_w) + IW'(gap_w) - 1'b1;
  assign idx[2*IW +: IW] = IW'({len_w, 1'b0}) + IW'(gap_w) - 1'b1;

  trap_delay_line #(.DW(DW), .DEPTH(DEPTH), .NT(3)) u_hist (
    .clk_i, .rst_ni, .clr_i(!run_i), .en_i(run_i), .d_i(sample_i),
    .idx_i(idx), .tap_o(taps)
  );

  trap_window_sum #(.DW(DW), .SW(SW)) u_sum_new (
    .clk_i, .rst_ni, .clr_i(!run_i), .en_i(run_i),
    .add_i(sample_i), .sub_i(taps[0*DW +: DW]), .sum_o(sum_new)
  );

  trap_window_sum #(.DW(DW), .SW(SW)) u_sum_old (
    .clk_i, .rst_ni, .clr_i(!run_i), .en_i(run_i),
    .add_i(taps[1*DW +: DW]), .sub_i(taps[2*DW +: DW]), .sum_o(sum_old)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_new_q <= '0;
      cap_old_q <= '0;
    end else if (cap_i) begin
      cap_new_q <= sum_new;
      cap_old_q <= sum_old;
    end
  end

  assign len_o     = len_w;
  assign gap_o     = gap_w;
  assign diff_o    = {1'b0, sum_new} - {1'b0, sum_old};
  assign cap_new_o = cap_new_q;
  assign cap_old_o = cap_old_q;
endmodule

// File: rtl/trap_filter_chk.sv
module trap_filter_chk #(
  parameter int DW = 16,
  parameter int LW = 7,
  parameter int GW = 6,
  parameter int SW = 22,
  parameter int L_MIN = 2,
  parameter int L_MAX = 64,
  parameter int G_MAX = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          cap_i,
  input logic [LW-1:0] len_o,
  input logic [GW-1:0] gap_o,
  input logic [SW:0]   diff_o,
  input logic          valid_o,
  input logic [SW-1:0] sum_new,
  input logic [SW-1:0] sum_old,
  input logic [SW-1:0] cap_new_o,
  input logic [SW-1:0] cap_old_o
);
  // R4
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (diff_o == '0 && !valid_o));
  // R3
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(len_o) && $stable(gap_o)));
  // R2
  param_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(len_o) >= L_MIN && int'(len_o) <= L_MAX && int'(gap_o) <= G_MAX));
  // R8
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (cap_new_o == $past(sum_new) && cap_old_o == $past(sum_old)));
  // R8
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(cap_new_o) && $stable(cap_old_o)));
  // R7
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && run_i) |=> valid_o);
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (64'(sum_new) <= 64'(len_o) * ((64'd1 << DW) - 1)));
endmodule

bind trap_filter trap_filter_chk #(
  .DW(DW), .LW(LW), .GW(GW), .SW(SW), .L_MIN(L_MIN), .L_MAX(L_MAX), .G_MAX(G_MAX)
) u_chk (
  .clk_i, .rst_ni, .run_i, .cap_i, .len_o, .gap_o, .diff_o, .valid_o,
  .sum_new, .sum_old, .cap_new_o, .cap_old_o
);

// File: tb/trap_filter_tb.sv
`timescale 1ns/1ps
module trap_filter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, load_i = 1'b0, cap_i = 1'b0;
  logic [6:0]  len_i = '0;
  logic [5:0]  gap_i = '0;
  logic [15:0] sample_i = '0;
  logic [6:0]  len_o;
  logic [5:0]  gap_o;
  logic [22:0] diff_o;
  logic        valid_o;
  logic [21:0] cap_new_o, cap_old_o;

  int errors = 0, checks = 0;
  int hist [200];
  int ml = 8, mg = 4, fill = 0;
  int ecn = 0, eco = 0, last_diff = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  trap_filter u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int m_new();
    int s = 0;
    for (int i = 0; i < ml; i++) s += hist[i];
    return s;
  endfunction

  function automatic int m_old();
    int s = 0;
    for (int i = ml + mg; i < 2 * ml + mg; i++) s += hist[i];
    return s;
  endfunction

  task automatic cyc(input bit run, input bit ld, input int ln, input int gp,
                     input int smp, input bit cp);
    int pn, po, ed;
    run_i = run; load_i = ld; len_i = 7'(ln); gap_i = 6'(gp);
    sample_i = 16'(smp); cap_i = cp;
    pn = m_new(); po = m_old();
    @(posedge clk_i);
    if (!run) begin
      for (int i = 0; i < 200; i++) hist[i] = 0;
      fill = 0;
      if (ld) begin ml = clampi(ln, 2, 64); mg = clampi(gp, 0, 32); end
    end else begin
      for (int i = 199; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = smp & 16'hFFFF;
      if (fill < 2 * ml + mg) fill++;
    end
    if (cp) begin ecn = pn; eco = po; end
    @(negedge clk_i);
    ed = m_new() - m_old();
    last_diff = $signed(diff_o);
    chk(last_diff == ed, run ? "R5 diff" : "R4 diff after idle", last_diff, ed);
    chk(valid_o == (fill == 2 * ml + mg), "R7 valid", int'(valid_o), int'(fill == 2 * ml + mg));
    chk(int'(len_o) == ml && int'(gap_o) == mg, (run && ld) ? "R3 params" : "R2 params",
        int'(len_o) * 100 + int'(gap_o), ml * 100 + mg);
    chk(int'(cap_new_o) == ecn && int'(cap_old_o) == eco, "R8 capture",
        int'(cap_new_o), ecn);
  endtask

  initial begin
    int nz, plat, maxd;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 200; i++) hist[i] = 0;
    #5;
    // R1 reset state
    chk(len_o == 7'd8 && gap_o == 6'd4, "R1 params", int'(len_o), 8);
    chk(valid_o == 1'b0 && diff_o == '0, "R1 outputs", int'(diff_o), 0);
    chk(cap_new_o == '0 && cap_old_o == '0, "R1 capture", int'(cap_new_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 step of height 1000, L=4 G=2
    cyc(0, 1, 4, 2, 0, 0);
    nz = 0; plat = 0;
    for (int k = 0; k < 16; k++) begin
      cyc(1, 0, 0, 0, 1000, 0);
      if (last_diff != 0) nz++;
      if (last_diff == 4000) plat++;
    end
    chk(plat == 3, "R6 plateau samples", plat, 3);
    chk(nz == 9, "R6 nonzero span", nz, 9);

    // R2 clamps, R4 idle clear
    cyc(0, 1, 1, 50, 0, 0);
    chk(len_o == 7'd2 && gap_o == 6'd32, "R2 clamp low/high", int'(len_o), 2);
    cyc(0, 1, 100, 0, 0, 0);
    chk(len_o == 7'd64, "R2 clamp length max", int'(len_o), 64);

    // R9 full scale at L=64 G=0
    maxd = 0;
    for (int k = 0; k < 140; k++) begin
      cyc(1, 0, 0, 0, 65535, k == 70);
      if (last_diff > maxd) maxd = last_diff;
    end
    chk(maxd == 4194240, "R9 peak", maxd, 4194240);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      cyc(0, 1, $urandom_range(127), $urandom_range(63), 0, $urandom_range(1));
      cyc(0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 200; k++)
        cyc(1, ($urandom_range(15) == 0), $urandom_range(127), $urandom_range(63),
            (r[0] ? $urandom_range(4095) : $urandom_range(65535)),
            ($urandom_range(7) == 0));
    end
    cyc(0, 0, 0, 0, 0, 0);
    chk(diff_o == '0 && !valid_o, "R4 final idle", int'(diff_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule